// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers sixteen single-cycle event pulses from the receive, transmit, bus and link logic of a network controller. Each pulse sets a sticky pending bit. Software reads the pending bits and clears them through a small byte-addressed register port. A separate enable register selects which pending bits may raise the one interrupt request line. A pending bit stays set until software writes a one to it, and it keeps capturing events while its enable is off. Software can therefore poll bits that it has chosen not to take as interrupts.

The register port takes one halfword per access. Bit 0 of the address is ignored. Two byte strobes select the low lane (bits 7:0) and the high lane (bits 15:8). Reads are combinational and show the current register contents. The request line is a flop fed from the pending and enable registers. It therefore follows them with one cycle of delay.

The block has no state machine. Its states are the contents of the two registers, and its transitions are set, clear and enable-write. All three are listed below.

Top module: `irq_status_mask`

## Requirements
- R1: After reset, the pending register (halfword offset 0x0C) reads 0x0000, the enable register (offset 0x0E) reads 0x0000, and `irq` is low.
- R2: An `ev_pulse[i]` high on a clock edge sets pending bit i. The bit then stays set until it is cleared. The bit sources are: 0 rx done, 2 rx error, 5 rx descriptor link error, 8 early rx, 10 rx FIFO overflow, 11 rx race, 12 rx out of buffers, 1 tx done, 3 tx error, 4 tx descriptor underflow, 9 tx FIFO underflow, 13 tx abort, 6 host bus error, 7 counter wrap, 14 link change, 15 general purpose.
- R3: A write to offset 0x0C clears each pending bit whose data bit is 1 in an enabled lane, and leaves bits written with 0 unchanged. Writing 0xFFFF with both lanes enabled clears every bit.
- R4: If a set event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x0E stores the data in the enabled lanes of the enable register, and a read of 0x0E returns the stored value.
- R6: Pending bits keep capturing events while their enable bit is 0. With the enable register at 0, `irq` stays low.
- R7: `irq` is high exactly when, in the previous cycle, some bit was both pending and enabled. It therefore rises or falls one cycle after the register change that causes it.
- R8: Strobe bit 0 selects data bits 7:0 and strobe bit 1 selects bits 15:8. A lane whose strobe is 0 is left untouched, for both the clear and the enable write.
- R9: A write to any halfword other than 0x0C or 0x0E changes neither register. A read of any other halfword returns 0x0000.
- R10: A read returns the register contents in the same cycle, including a bit set by the event on the edge just before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Byte address of the access (bit 0 ignored) |
| reg_wr | input | 1 | Write enable for this cycle |
| reg_be | input | 2 | Byte-lane strobes for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ev_pulse | input | 16 | One pulse per event source, sets the matching pending bit |
| irq | output | 1 | Registered interrupt request |

## Verification
An event can set a pending bit in the same cycle that software writes a one to clear that bit. The bench provokes this by driving a clearing write and an `ev_pulse` on the same bit in one cycle. It does so once for a bit that was already pending and once for a bit that was idle. In both cases the bench expects the bit to read back as set. A reference model updated on every edge also judges `irq` in the cycles that follow.

// File: rtl/ism_pkg.sv
package ism_pkg;
    localparam int REG_W   = 16;
    localparam int LANE_W  = 8;
    localparam int N_LANES = REG_W / LANE_W;

    // Event source bit positions; software decodes these.
    localparam int EV_RX_DONE   = 0;
    localparam int EV_TX_DONE   = 1;
    localparam int EV_RX_ERR    = 2;
    localparam int EV_TX_ERR    = 3;
    localparam int EV_TX_DUNDER = 4;
    localparam int EV_RX_LINK   = 5;
    localparam int EV_BUS_ERR   = 6;
    localparam int EV_CNT_WRAP  = 7;
    localparam int EV_RX_EARLY  = 8;
    localparam int EV_TX_FUNDER = 9;
    localparam int EV_RX_FOVER  = 10;
    localparam int EV_RX_RACE   = 11;
    localparam int EV_RX_NOBUF  = 12;
    localparam int EV_TX_ABORT  = 13;
    localparam int EV_LINK_CHG  = 14;
    localparam int EV_GENERAL   = 15;

    typedef logic [REG_W-1:0] reg_word_t;

    function automatic reg_word_t lane_mask(input logic [N_LANES-1:0] be);
        reg_word_t m;
        for (int l = 0; l < N_LANES; l++)
            m[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
        return m;
    endfunction
endpackage

// File: rtl/ism_status_bank.sv
module ism_status_bank
    import ism_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  reg_word_t ev,
    input  reg_word_t clr,
    output reg_word_t status
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (ev[i])
                status[i] <= 1'b1;   // set wins over clear
            else if (clr[i])
                status[i] <= 1'b0;
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev))); // R2 R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~ev) != '0) |=> ((status & $past(clr & ~ev)) == '0)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev == '0) && (clr == '0)) |=> $stable(status)); // R2
endmodule

// File: rtl/ism_mask_bank.sv
module ism_mask_bank
    import ism_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  reg_word_t lanes,
    input  reg_word_t wdata,
    output reg_word_t mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (wr_hit)
            mask <= (mask & ~lanes) | (wdata & lanes);
    end

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(mask)); // R5

    AST_MASK_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((mask & ~$past(lanes)) == ($past(mask) & ~$past(lanes)))); // R8
endmodule

// File: rtl/ism_irq_out.sv
module ism_irq_out
    import ism_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  reg_word_t status,
    input  reg_word_t mask,
    output logic      irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(status & mask);
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq); // R6

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(status) != '0)); // R7
endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask
    import ism_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int STATUS_OFS = 'h0C,
    parameter int MASK_OFS   = 'h0E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [1:0]         reg_be,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    input  logic [15:0]        ev_pulse,
    output logic               irq
);
    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] MK_ADDR = ADDR_W'(MASK_OFS);

    logic      sel_status, sel_mask;
    reg_word_t lanes, clr_vec, status_q, mask_q;

    assign sel_status = (reg_addr[ADDR_W-1:1] == ST_ADDR[ADDR_W-1:1]);
    assign sel_mask   = (reg_addr[ADDR_W-1:1] == MK_ADDR[ADDR_W-1:1]);
    assign lanes      = lane_mask(reg_be);
    assign clr_vec    = (reg_wr && sel_status) ? (reg_wdata & lanes) : '0;

    ism_status_bank u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_pulse),
        .clr    (clr_vec),
        .status (status_q)
    );

    ism_mask_bank u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (reg_wr && sel_mask),
        .lanes  (lanes),
        .wdata  (reg_wdata),
        .mask   (mask_q)
    );

    ism_irq_out u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .mask   (mask_q),
        .irq    (irq)
    );

    always_comb begin
        if (sel_status)
            reg_rdata = status_q;
        else if (sel_mask)
            reg_rdata = mask_q;
        else
            reg_rdata = '0;
    end

    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !sel_status && !sel_mask && (ev_pulse == '0)) |=>
            ($stable(status_q) && $stable(mask_q))); // R9
endmodule

// File: tb/tb_irq_status_mask.sv
module tb_irq_status_mask;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] ev_pulse = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    logic [15:0] m_st = '0, m_mk = '0;
    logic        m_irq = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_status_mask dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_pulse(ev_pulse), .irq(irq)
    );

    function automatic logic [15:0] lanes_of(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= '0; m_mk <= '0; m_irq <= 1'b0;
        end else begin
            logic [15:0] c;
            c = '0;
            if (reg_wr && reg_addr[7:1] == 7'h06) c = reg_wdata & lanes_of(reg_be);
            m_st  <= (m_st & ~c) | ev_pulse;
            if (reg_wr && reg_addr[7:1] == 7'h07)
                m_mk <= (m_mk & ~lanes_of(reg_be)) | (reg_wdata & lanes_of(reg_be));
            m_irq <= (m_st & m_mk) != 0;
        end
    end

    function automatic logic [15:0] m_read(input logic [7:0] a);
        if (a[7:1] == 7'h06) return m_st;
        if (a[7:1] == 7'h07) return m_mk;
        return 16'h0000;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7 irq vs model", {15'd0, irq}, {15'd0, m_irq});
            chk("R10 rdata vs model", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic idle();
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0; ev_pulse = '0;
    endtask

    task automatic cyc(input logic [7:0] a, input logic wr, input logic [1:0] be,
                       input logic [15:0] d, input logic [15:0] ev);
        @(posedge clk); #2;
        reg_addr = a; reg_wr = wr; reg_be = be; reg_wdata = d; ev_pulse = ev;
        @(posedge clk); #2;
        idle();
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_at_next(input logic exp, input string tag);
        @(negedge clk);
        chk(tag, {15'd0, irq}, {15'd0, exp});
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_on = 1'b1;
        rd(8'h0C, 16'h0000, "R1 status after reset");
        rd(8'h0E, 16'h0000, "R1 mask after reset");
        chk("R1 irq after reset", {15'd0, irq}, 16'd0);

        // R2 / R10: set and sticky
        cyc(8'h0C, 1'b0, 2'b00, 16'h0, 16'h0001);
        rd(8'h0C, 16'h0001, "R10 live read after event");
        cyc(8'h0C, 1'b0, 2'b00, 16'h0, 16'h8420);
        rd(8'h0C, 16'h8421, "R2 events accumulate");
        repeat (3) @(posedge clk);
        rd(8'h0C, 16'h8421, "R2 bits sticky");
        chk("R6 masked irq low", {15'd0, irq}, 16'd0);

        // R5 / R7: enable bit 10
        cyc(8'h0E, 1'b1, 2'b11, 16'h0400, 16'h0);
        rd(8'h0E, 16'h0400, "R5 mask readback");
        chk("R7 irq not yet", {15'd0, irq}, 16'd0);
        irq_at_next(1'b1, "R7 irq one cycle later");

        // R3: clear bits 10 and 0
        cyc(8'h0C, 1'b1, 2'b11, 16'h0401, 16'h0);
        rd(8'h0C, 16'h8020, "R3 w1c selected bits");
        chk("R7 irq holds one cycle", {15'd0, irq}, 16'd1);
        irq_at_next(1'b0, "R7 irq falls");

        // R8: byte lanes
        cyc(8'h0C, 1'b1, 2'b01, 16'hFFFF, 16'h0);
        rd(8'h0C, 16'h8000, "R8 low lane clear only");
        cyc(8'h0E, 1'b1, 2'b10, 16'hABCD, 16'h0);
        rd(8'h0E, 16'hAB00, "R8 high lane mask only");
        irq_at_next(1'b1, "R7 irq from bit 15");

        // R9: other addresses
        cyc(8'h0A, 1'b1, 2'b11, 16'hFFFF, 16'h0);
        cyc(8'h10, 1'b1, 2'b11, 16'hFFFF, 16'h0);
        rd(8'h0C, 16'h8000, "R9 status untouched");
        rd(8'h0E, 16'hAB00, "R9 mask untouched");
        rd(8'h00, 16'h0000, "R9 other read zero");

        // R4: set and clear in the same cycle
        cyc(8'h0C, 1'b1, 2'b11, 16'h8002, 16'h8002);
        rd(8'h0C, 16'h8002, "R4 event wins over clear");
        cyc(8'h0C, 1'b1, 2'b11, 16'hFFFF, 16'h0);
        rd(8'h0C, 16'h0000, "R3 clear all");

        // R6: masked capture
        cyc(8'h0E, 1'b1, 2'b11, 16'h0000, 16'h0);
        cyc(8'h0C, 1'b0, 2'b00, 16'h0, 16'hFFFF);
        rd(8'h0C, 16'hFFFF, "R6 latch while masked");
        irq_at_next(1'b0, "R6 irq low with mask zero");
        irq_at_next(1'b0, "R6 irq still low");
        cyc(8'h0E, 1'b1, 2'b11, 16'h0001, 16'h0);
        irq_at_next(1'b0, "R7 irq delay after enable");
        irq_at_next(1'b1, "R7 irq after enable");
        cyc(8'h0C, 1'b1, 2'b11, 16'hFFFF, 16'h0);
        irq_at_next(1'b1, "R7 irq delay after clear");
        irq_at_next(1'b0, "R3 irq gone after clear all");

        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule